// File: doc/BRIEF.md
# Prefix Relocation and Storage-Key Updater

This block sits between a processor's address path and main storage. For every access it turns a real address into an absolute address by swapping two 8 KB windows. The lowest 8 KB of real storage is moved to the per-processor prefix area, and the prefix area is moved down to address zero. While it relocates, it clips the access length so that the access never runs past the edge of a swapped window. It then compares the absolute address with the installed memory size and raises an addressing exception when the address lies outside it.

For accesses that fall inside memory, the block updates a per-page key entry held in an external key array (4 KB pages, 7-bit entries). The reference bit is set when read permission is granted, and the change bit is set when write permission is granted. Each update is a read-modify-write over two cycles, run by a four-state machine. In IDLE no update is in flight. In FETCH a key read is outstanding. In OVERLAP one page is being written while the read for the next page is outstanding. In COMMIT the last write is retired.

The next state depends only on whether the current state holds an outstanding read and whether a new update arrives:

| Current state | New update arrives | No new update |
|---|---|---|
| IDLE | FETCH | IDLE |
| FETCH | OVERLAP | COMMIT |
| OVERLAP | OVERLAP | COMMIT |
| COMMIT | FETCH | IDLE |

When two updates to the same page follow each other, the value being written is forwarded to the later update in place of the stale array data.

Top module: `prefix_key_unit`

## Requirements
- R1: A real address below 8192 maps to the 8 KB-aligned prefix plus the address. Bits 12:0 of the prefix input are ignored. This window has priority when the prefix is zero.
- R2: A real address in [prefix, prefix+8192) maps to the address minus the prefix.
- R3: Any other real address passes through unchanged, and its length is not modified.
- R4: Inside either window the returned length is min(length, 8192 - offset within the window).
- R5: rsp_valid is high exactly in the cycle after a cycle with req_valid high. In that cycle abs_addr, clip_len and addr_exc describe that request.
- R6: addr_exc is high when the absolute address is greater than or equal to mem_size.
- R7: For an in-range access with read permission, bit 2 (reference) of the key entry of page abs_addr[21:12] becomes 1. All other bits keep their value.
- R8: For an in-range access with write permission, bit 1 (change) of that key entry becomes 1. All other bits keep their value.
- R9: An access that raises addr_exc, or that has neither permission, never writes the key array.
- R10: The key array is read with key_raddr in the response cycle. key_we is high with key_waddr equal to the page in the following cycle. The array is assumed to return the old data on a read to an address written in the same cycle.
- R11: Back-to-back updates to the same page accumulate: no bit set by the earlier update is lost.
- R12: After reset, rsp_valid and key_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| real_addr | input | 22 | Real byte address |
| req_len | input | 14 | Requested length in bytes |
| prefix | input | 22 | Prefix register (low 13 bits ignored) |
| perm_rd | input | 1 | Read permission granted |
| perm_wr | input | 1 | Write permission granted |
| mem_size | input | 22 | Installed memory size in bytes |
| rsp_valid | output | 1 | Response valid |
| abs_addr | output | 22 | Absolute address |
| clip_len | output | 14 | Length clipped to the window |
| addr_exc | output | 1 | Addressing exception |
| key_raddr | output | 10 | Key array read page |
| key_rdata | input | 7 | Key array read data, one cycle after key_raddr |
| key_we | output | 1 | Key array write enable |
| key_waddr | output | 10 | Key array write page |
| key_wdata | output | 7 | Key array write data |

## Verification
The hardest situation to reach is an OVERLAP cycle in which the page being written equals the page being read. Only in that cycle does the array return stale data, so only then does forwarding matter. Uniform random addresses almost never hit this case. The stimulus therefore reuses the previous page for about a quarter of the random accesses and issues them with no idle gap. Directed runs of two and three same-page accesses with mixed permissions also drive this case, and the final key contents are compared with a bench-side model.

// File: rtl/pku_pkg.sv
package pku_pkg;
    localparam int KEY_W   = 7;
    localparam int REF_BIT = 2;
    localparam int CHG_BIT = 1;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_FETCH,
        KS_OVERLAP,
        KS_COMMIT
    } key_state_t;
endpackage

// File: rtl/pku_reloc.sv
module pku_reloc #(
    parameter int ADDR_W   = 22,
    parameter int LEN_W    = 14,
    parameter int WIN_BITS = 13
) (
    input  logic [ADDR_W-1:0] real_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] prefix,
    input  logic [ADDR_W-1:0] mem_size,
    output logic [ADDR_W-1:0] abs_addr,
    output logic [LEN_W-1:0]  clip_len,
    output logic              in_range
);
    localparam int HI_W = ADDR_W - WIN_BITS;
    localparam logic [LEN_W-1:0] WIN_LEN = LEN_W'(1) << WIN_BITS;

    logic [ADDR_W-1:0] pfx_base;
    logic              hit_low;
    logic              hit_pfx;
    logic [LEN_W-1:0]  remain;

    // Prefix is 8 KB aligned by construction of the base.
    assign pfx_base = {prefix[ADDR_W-1:WIN_BITS], {WIN_BITS{1'b0}}};
    assign hit_low  = (real_addr[ADDR_W-1:WIN_BITS] == HI_W'(0));
    assign hit_pfx  = (real_addr[ADDR_W-1:WIN_BITS] == prefix[ADDR_W-1:WIN_BITS]);
    assign remain   = WIN_LEN - LEN_W'(real_addr[WIN_BITS-1:0]);

    always_comb begin
        abs_addr = real_addr;
        clip_len = req_len;
        if (hit_low) begin
            abs_addr = pfx_base + real_addr;
            clip_len = (req_len > remain) ? remain : req_len;
        end else if (hit_pfx) begin
            abs_addr = real_addr - pfx_base;
            clip_len = (req_len > remain) ? remain : req_len;
        end
    end

    assign in_range = (abs_addr < mem_size);
endmodule

// File: rtl/pku_key_fsm.sv
module pku_key_fsm
    import pku_pkg::*;
#(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic [KEY_W-1:0]  upd_mask,
    output logic [PAGE_W-1:0] key_raddr,
    input  logic [KEY_W-1:0]  key_rdata,
    output logic              key_we,
    output logic [PAGE_W-1:0] key_waddr,
    output logic [KEY_W-1:0]  key_wdata
);
    key_state_t state, state_nx;

    logic [PAGE_W-1:0] s1_page, s2_page;
    logic [KEY_W-1:0]  s1_mask, s2_mask;
    logic              fwd_hit;
    logic [KEY_W-1:0]  fwd_key;
    logic              s1_busy, s2_busy;

    assign s1_busy = (state == KS_FETCH) || (state == KS_OVERLAP);
    assign s2_busy = (state == KS_OVERLAP) || (state == KS_COMMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            KS_IDLE:    state_nx = upd_valid ? KS_FETCH   : KS_IDLE;
            KS_FETCH:   state_nx = upd_valid ? KS_OVERLAP : KS_COMMIT;
            KS_OVERLAP: state_nx = upd_valid ? KS_OVERLAP : KS_COMMIT;
            KS_COMMIT:  state_nx = upd_valid ? KS_FETCH   : KS_IDLE;
            default:    state_nx = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_page <= '0;
            s1_mask <= '0;
            s2_page <= '0;
            s2_mask <= '0;
            fwd_hit <= 1'b0;
            fwd_key <= '0;
        end else begin
            if (upd_valid) begin
                s1_page <= upd_page;
                s1_mask <= upd_mask;
            end
            if (s1_busy) begin
                s2_page <= s1_page;
                s2_mask <= s1_mask;
            end
            fwd_hit <= s1_busy && s2_busy && (s1_page == s2_page);
            fwd_key <= key_wdata;
        end
    end

    always_comb begin
        key_raddr = s1_page;
        key_we    = s2_busy;
        key_waddr = s2_page;
        key_wdata = (fwd_hit ? fwd_key : key_rdata) | s2_mask;
    end

    // R10
    fetch_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ##1 (key_we && key_waddr == $past(upd_page, 2)));

    // R11
    merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && $past(key_we) && key_waddr == $past(key_waddr))
        |-> ((key_wdata & $past(key_wdata)) == $past(key_wdata)));

    // R9
    write_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we |-> (key_wdata[REF_BIT] || key_wdata[CHG_BIT]));
endmodule

// File: rtl/prefix_key_unit.sv
module prefix_key_unit
    import pku_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int LEN_W     = 14,
    parameter int WIN_BITS  = 13,
    parameter int PAGE_BITS = 12,
    localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] real_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] prefix,
    input  logic              perm_rd,
    input  logic              perm_wr,
    input  logic [ADDR_W-1:0] mem_size,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] abs_addr,
    output logic [LEN_W-1:0]  clip_len,
    output logic              addr_exc,
    output logic [PAGE_W-1:0] key_raddr,
    input  logic [KEY_W-1:0]  key_rdata,
    output logic              key_we,
    output logic [PAGE_W-1:0] key_waddr,
    output logic [KEY_W-1:0]  key_wdata
);
    logic [ADDR_W-1:0] rel_addr;
    logic [LEN_W-1:0]  rel_len;
    logic              rel_ok;
    logic              upd_valid;
    logic [KEY_W-1:0]  upd_mask;

    pku_reloc #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .WIN_BITS (WIN_BITS)
    ) u_reloc (
        .real_addr (real_addr),
        .req_len   (req_len),
        .prefix    (prefix),
        .mem_size  (mem_size),
        .abs_addr  (rel_addr),
        .clip_len  (rel_len),
        .in_range  (rel_ok)
    );

    always_comb begin
        upd_mask          = '0;
        upd_mask[REF_BIT] = perm_rd;
        upd_mask[CHG_BIT] = perm_wr;
        upd_valid         = req_valid && rel_ok && (perm_rd || perm_wr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            abs_addr  <= '0;
            clip_len  <= '0;
            addr_exc  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                abs_addr <= rel_addr;
                clip_len <= rel_len;
                addr_exc <= !rel_ok;
            end
        end
    end

    pku_key_fsm #(
        .PAGE_W (PAGE_W)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_page  (rel_addr[ADDR_W-1:PAGE_BITS]),
        .upd_mask  (upd_mask),
        .key_raddr (key_raddr),
        .key_rdata (key_rdata),
        .key_we    (key_we),
        .key_waddr (key_waddr),
        .key_wdata (key_wdata)
    );

    // R5
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R4
    clip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> clip_len <= $past(req_len));

    // R9
    exc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && addr_exc) |=> !key_we);

    // R1
    low_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(real_addr[ADDR_W-1:WIN_BITS]) == '0)
        |-> abs_addr[WIN_BITS-1:0] == $past(real_addr[WIN_BITS-1:0]));
endmodule

// File: tb/tb_prefix_key_unit.sv
`timescale 1ns/1ps
module tb_prefix_key_unit;
    localparam int AW = 22;
    localparam int LW = 14;
    localparam int PW = 10;
    localparam int NPAGE = 1 << PW;
    localparam logic [AW-1:0] MEMSZ = 22'h300000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] real_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [AW-1:0] prefix = '0;
    logic          perm_rd = 1'b0;
    logic          perm_wr = 1'b0;
    logic [AW-1:0] mem_size = MEMSZ;
    logic          rsp_valid;
    logic [AW-1:0] abs_addr;
    logic [LW-1:0] clip_len;
    logic          addr_exc;
    logic [PW-1:0] key_raddr;
    logic [6:0]    key_rdata;
    logic          key_we;
    logic [PW-1:0] key_waddr;
    logic [6:0]    key_wdata;

    int checks = 0;
    int errors = 0;

    logic [6:0] kmem   [NPAGE];
    logic [6:0] shadow [NPAGE];

    always #2.5 clk = ~clk;

    prefix_key_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .real_addr(real_addr),
        .req_len(req_len), .prefix(prefix), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .mem_size(mem_size), .rsp_valid(rsp_valid), .abs_addr(abs_addr),
        .clip_len(clip_len), .addr_exc(addr_exc), .key_raddr(key_raddr),
        .key_rdata(key_rdata), .key_we(key_we), .key_waddr(key_waddr),
        .key_wdata(key_wdata)
    );

    function automatic logic [6:0] init_key(int i);
        return 7'((i * 29) + 3) & 7'h79;
    endfunction

    // Key array model: read returns old data on same-cycle write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAGE; i++) kmem[i] <= init_key(i);
            key_rdata <= '0;
        end else begin
            if (key_we) kmem[key_waddr] <= key_wdata;
            key_rdata <= kmem[key_raddr];
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_map(input logic [AW-1:0] a, input logic [LW-1:0] l,
                              input logic [AW-1:0] p, output logic [AW-1:0] ea,
                              output logic [LW-1:0] el);
        longint base, room;
        base = longint'(p) - (longint'(p) % 8192);
        ea = a;
        el = l;
        room = -1;
        if (a < 8192) begin
            ea = AW'(base + a);
            room = 8192 - a;
        end else if (longint'(a) >= base && longint'(a) < base + 8192) begin
            ea = AW'(longint'(a) - base);
            room = 8192 - (longint'(a) - base);
        end
        if (room >= 0 && longint'(l) > room) el = LW'(room);
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [LW-1:0] l,
                         input logic rd, input logic wr, input string tag);
        logic [AW-1:0] ea;
        logic [LW-1:0] el;
        logic          eexc;
        expect_map(a, l, prefix, ea, el);
        eexc = (ea >= mem_size);
        real_addr = a; req_len = l; perm_rd = rd; perm_wr = wr; req_valid = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b1, {"R5 ", tag}, rsp_valid, 1);
        chk(abs_addr == ea, {"R1/R2/R3 abs ", tag}, abs_addr, ea);
        chk(clip_len == el, {"R4 clip ", tag}, clip_len, el);
        chk(addr_exc == eexc, {"R6 exc ", tag}, addr_exc, eexc);
        if (!eexc) begin
            if (rd) shadow[ea[AW-1:12]][2] = 1'b1;
            if (wr) shadow[ea[AW-1:12]][1] = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic page_chk(input logic [PW-1:0] pg, input string tag);
        chk(kmem[pg] == shadow[pg], tag, kmem[pg], shadow[pg]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] last_a;
        int mism;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < NPAGE; i++) shadow[i] = init_key(i);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(rsp_valid == 1'b0, "R12 rsp_valid in reset", rsp_valid, 0);
        chk(key_we == 1'b0, "R12 key_we in reset", key_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && key_we == 1'b0, "R12 after reset", {rsp_valid, key_we}, 0);

        prefix = 22'h024000;
        issue(22'h000100, 14'd16, 1, 0, "R1 low window");
        idle(1);
        // R10 write follows one cycle after the response
        chk(key_we == 1'b1 && key_waddr == PW'(22'h024100 >> 12), "R10 write slot",
            {key_we, key_waddr}, {1'b1, PW'(22'h024100 >> 12)});
        idle(2);
        page_chk(PW'(22'h024100 >> 12), "R7 reference bit");
        issue(22'h001ff0, 14'd64, 0, 1, "R4 clip low");
        issue(22'h025000, 14'h2000, 0, 1, "R2 prefix window");
        issue(22'h100000, 14'd300, 1, 1, "R3 pass-through");
        idle(3);
        page_chk(PW'(22'h025ff0 >> 12), "R8 change bit");
        page_chk(PW'(22'h000001), "R2 R8 key of swapped page");

        // R6 and R9: exception, no key write
        issue(22'h3f0000, 14'd8, 1, 1, "R6 beyond memory");
        idle(1);
        chk(key_we == 1'b0, "R9 no write on exception", key_we, 0);
        idle(1);
        chk(key_we == 1'b0, "R9 no write on exception late", key_we, 0);
        page_chk(PW'(22'h3f0000 >> 12), "R9 exception page untouched");
        issue(22'h0a0000, 14'd8, 0, 0, "R9 no permission");
        idle(1);
        chk(key_we == 1'b0, "R9 no write without permission", key_we, 0);
        idle(2);
        page_chk(PW'(22'h0a0000 >> 12), "R9 no-permission page untouched");

        // R11 back-to-back same page
        issue(22'h050000, 14'd4, 1, 0, "R11 first");
        issue(22'h050800, 14'd4, 0, 1, "R11 second");
        idle(3);
        page_chk(PW'(22'h050000 >> 12), "R11 two same-page updates");
        issue(22'h061000, 14'd4, 0, 1, "R11 triple a");
        issue(22'h061100, 14'd4, 0, 1, "R11 triple b");
        issue(22'h061200, 14'd4, 1, 0, "R11 triple c");
        idle(3);
        page_chk(PW'(22'h061000 >> 12), "R11 three same-page updates");

        // R1 prefix zero and unaligned prefix bits
        prefix = 22'h000000;
        issue(22'h000040, 14'd8, 1, 0, "R1 prefix zero");
        prefix = 22'h024123;
        issue(22'h000010, 14'd8, 1, 0, "R1 prefix low bits ignored");
        idle(3);

        // Random phase
        last_a = 22'h010000;
        for (int i = 0; i < 2000; i++) begin
            logic [AW-1:0] a;
            int kind;
            if (i % 64 == 0) prefix = AW'($urandom) & 22'h3fe000;
            kind = $urandom_range(0, 3);
            if (kind == 0)      a = AW'($urandom_range(0, 8191));
            else if (kind == 1) a = {prefix[AW-1:13], 13'($urandom)};
            else if (kind == 2) a = {last_a[AW-1:12], 12'($urandom)};
            else                a = AW'($urandom);
            issue(a, LW'($urandom), 1'($urandom), 1'($urandom), "random");
            last_a = a;
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(4);
        mism = 0;
        for (int i = 0; i < NPAGE; i++) if (kmem[i] != shadow[i]) mism++;
        chk(mism == 0, "R7 R8 R11 final key array mismatches", mism, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule